// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for each instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each of its two ALU operands should come from. The candidates are the value read from the register file and latched at decode, the result held in the execute/memory pipeline register, and the result held in the memory/writeback pipeline register. The block compares the execute-stage source register numbers with the single destination register and write-enable flag carried by each of the two later stages. It then emits a 2-bit select code per operand and drives the chosen value through its own operand multiplexer.

A second path handles a store that sits in the memory stage right behind a load that has reached writeback. When the store's data register is the load's destination, the memory write data is taken from the writeback register instead of the stale copy carried down the pipe. Every output is a pure combinational function of the current pipeline register contents. Register zero is hard-wired and is never a forwarding source.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 (execute/memory) whenever `xm_wr_en` is high, `xm_rd` equals `ex_rs_a`, and `ex_rs_a` is not zero.
- R2: `sel_b` is 2'b10 under the same condition, matched against `ex_rs_b`.
- R3: An operand select is 2'b01 (memory/writeback) when `mw_wr_en` is high, `mw_rd` equals that source register, the source is not zero, and the execute/memory stage is not writing that same register.
- R4: When neither later stage supplies a match, the operand select is 2'b00 and the operand equals the latched register file value.
- R5: When both later stages write the register an operand needs, the execute/memory result (the newer one) wins and the select is 2'b10.
- R6: A source register number of zero never produces a forwarding select on `sel_a`, `sel_b` or `sel_st`, whatever the later stages hold.
- R7: `sel_st` is 1 and `st_wdata` equals `mw_result` exactly when `mem_is_store`, `mw_is_load` and `mw_wr_en` are all high and `mem_st_reg` equals a nonzero `mw_rd`; otherwise `sel_st` is 0 and `st_wdata` equals `mem_st_data`.
- R8: The operand select code 2'b11 is never produced.
- R9: `op_a` and `op_b` equal `ex_rf_*`, `mw_result` or `xm_result` for select codes 2'b00, 2'b01 and 2'b10 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs_a | input | REG_W | First source register number of the execute-stage instruction |
| ex_rs_b | input | REG_W | Second source register number of the execute-stage instruction |
| ex_rf_a | input | DATA_W | Register file value for the first source, latched at decode |
| ex_rf_b | input | DATA_W | Register file value for the second source, latched at decode |
| xm_wr_en | input | 1 | Execute/memory instruction writes a register |
| xm_rd | input | REG_W | Execute/memory destination register number |
| xm_result | input | DATA_W | Execute/memory ALU result |
| mw_wr_en | input | 1 | Memory/writeback instruction writes a register |
| mw_is_load | input | 1 | Memory/writeback instruction is a load |
| mw_rd | input | REG_W | Memory/writeback destination register number |
| mw_result | input | DATA_W | Memory/writeback write-back value |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_reg | input | REG_W | Register number supplying the store data |
| mem_st_data | input | DATA_W | Store data carried down from execute |
| sel_a | output | 2 | Select code for the first ALU operand |
| sel_b | output | 2 | Select code for the second ALU operand |
| sel_st | output | 1 | Store data taken from memory/writeback |
| op_a | output | DATA_W | Selected first ALU operand |
| op_b | output | DATA_W | Selected second ALU operand |
| st_wdata | output | DATA_W | Selected memory write data |

## Verification
Every select and every selected value is due in the same cycle its inputs change, with no register in between, so zero cycles separate a stimulus from its result. The bench changes all inputs on the falling clock edge and samples the outputs one nanosecond later, well inside the same half period, so no result depends on an edge. Register-number tuples modelled on short dependent instruction sequences are walked from a table, and directed cases then cover the store path and register zero.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand source codes. The encoding is relied on by the datapath
   // multiplexer and by the checker; 2'b11 is reserved and never driven.
   typedef enum logic [1:0] {
      FWD_RF = 2'b00,
      FWD_WB = 2'b01,
      FWD_XM = 2'b10
   } fwd_sel_e;

   localparam int unsigned FWD_SEL_W = 2;

endpackage

// File: rtl/fwd_match.sv
// Per-operand comparator: picks the newest in-flight producer of one source.
module fwd_match
   import fwd_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic             xm_we,
   input  logic [REG_W-1:0] xm_rd,
   input  logic             mw_we,
   input  logic [REG_W-1:0] mw_rd,
   output fwd_sel_e         sel
);

   logic src_live;
   logic xm_hit;
   logic mw_hit;

   generate
      if (SKIP_ZERO) begin : g_zero_guard
         assign src_live = |src;
      end else begin : g_no_guard
         assign src_live = 1'b1;
      end
   endgenerate

   assign xm_hit = xm_we && (xm_rd == src) && src_live;
   assign mw_hit = mw_we && (mw_rd == src) && src_live;

   // Newer stage first: a younger write shadows an older one.
   always_comb begin
      if (xm_hit) begin
         sel = FWD_XM;
      end else if (mw_hit) begin
         sel = FWD_WB;
      end else begin
         sel = FWD_RF;
      end
   end

endmodule

// File: rtl/fwd_mux3.sv
// Three-way operand multiplexer steered by a forwarding code.
module fwd_mux3
   import fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] d_rf,
   input  logic [DATA_W-1:0] d_wb,
   input  logic [DATA_W-1:0] d_xm,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (sel)
         FWD_XM:  y = d_xm;
         FWD_WB:  y = d_wb;
         default: y = d_rf;
      endcase
   end

endmodule

// File: rtl/fwd_store_bypass.sv
// Memory-stage store data bypass from a load completing in writeback.
module fwd_store_bypass #(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          SKIP_ZERO = 1'b1,
   parameter bit          ENABLE    = 1'b1
) (
   input  logic              mem_store,
   input  logic [REG_W-1:0]  st_reg,
   input  logic [DATA_W-1:0] st_data,
   input  logic              wb_load,
   input  logic              wb_we,
   input  logic [REG_W-1:0]  wb_rd,
   input  logic [DATA_W-1:0] wb_data,
   output logic              sel,
   output logic [DATA_W-1:0] wdata
);

   generate
      if (ENABLE) begin : g_bypass
         logic reg_live;
         if (SKIP_ZERO) begin : g_zero_guard
            assign reg_live = |st_reg;
         end else begin : g_no_guard
            assign reg_live = 1'b1;
         end
         assign sel = mem_store && wb_load && wb_we && reg_live && (st_reg == wb_rd);
      end else begin : g_no_bypass
         assign sel = 1'b0;
      end
   endgenerate

   assign wdata = sel ? wb_data : st_data;

endmodule

// File: rtl/fwd_unit.sv
// Top: operand forwarding for the execute stage plus the store-data bypass.
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_W        = 5,
   parameter int unsigned DATA_W       = 32,
   parameter bit          SKIP_ZERO    = 1'b1,
   parameter bit          STORE_BYPASS = 1'b1
) (
   input  logic [REG_W-1:0]  ex_rs_a,
   input  logic [REG_W-1:0]  ex_rs_b,
   input  logic [DATA_W-1:0] ex_rf_a,
   input  logic [DATA_W-1:0] ex_rf_b,
   input  logic              xm_wr_en,
   input  logic [REG_W-1:0]  xm_rd,
   input  logic [DATA_W-1:0] xm_result,
   input  logic              mw_wr_en,
   input  logic              mw_is_load,
   input  logic [REG_W-1:0]  mw_rd,
   input  logic [DATA_W-1:0] mw_result,
   input  logic              mem_is_store,
   input  logic [REG_W-1:0]  mem_st_reg,
   input  logic [DATA_W-1:0] mem_st_data,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic              sel_st,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] st_wdata
);

   localparam int unsigned NUM_OPS = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $error("fwd_unit: REG_W must be 1..8");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("fwd_unit: DATA_W must be positive");
      end
   endgenerate

   logic     [REG_W-1:0]  src_v [NUM_OPS];
   logic     [DATA_W-1:0] rf_v  [NUM_OPS];
   logic     [DATA_W-1:0] op_v  [NUM_OPS];
   fwd_sel_e              sel_v [NUM_OPS];

   assign src_v[0] = ex_rs_a;
   assign src_v[1] = ex_rs_b;
   assign rf_v[0]  = ex_rf_a;
   assign rf_v[1]  = ex_rf_b;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
         fwd_match #(
            .REG_W    (REG_W),
            .SKIP_ZERO(SKIP_ZERO)
         ) u_match (
            .src  (src_v[g]),
            .xm_we(xm_wr_en),
            .xm_rd(xm_rd),
            .mw_we(mw_wr_en),
            .mw_rd(mw_rd),
            .sel  (sel_v[g])
         );

         fwd_mux3 #(
            .DATA_W(DATA_W)
         ) u_mux (
            .sel (sel_v[g]),
            .d_rf(rf_v[g]),
            .d_wb(mw_result),
            .d_xm(xm_result),
            .y   (op_v[g])
         );
      end
   endgenerate

   assign sel_a = sel_v[0];
   assign sel_b = sel_v[1];
   assign op_a  = op_v[0];
   assign op_b  = op_v[1];

   fwd_store_bypass #(
      .REG_W    (REG_W),
      .DATA_W   (DATA_W),
      .SKIP_ZERO(SKIP_ZERO),
      .ENABLE   (STORE_BYPASS)
   ) u_store (
      .mem_store(mem_is_store),
      .st_reg   (mem_st_reg),
      .st_data  (mem_st_data),
      .wb_load  (mw_is_load),
      .wb_we    (mw_wr_en),
      .wb_rd    (mw_rd),
      .wb_data  (mw_result),
      .sel      (sel_st),
      .wdata    (st_wdata)
   );

endmodule

// File: rtl/fwd_unit_chk.sv
// Checker bound to fwd_unit; all properties are combinational relations.
module fwd_unit_chk #(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input logic [REG_W-1:0]  ex_rs_a,
   input logic [REG_W-1:0]  ex_rs_b,
   input logic [DATA_W-1:0] ex_rf_a,
   input logic [DATA_W-1:0] ex_rf_b,
   input logic              xm_wr_en,
   input logic [REG_W-1:0]  xm_rd,
   input logic [DATA_W-1:0] xm_result,
   input logic              mw_wr_en,
   input logic [REG_W-1:0]  mw_rd,
   input logic [DATA_W-1:0] mw_result,
   input logic [REG_W-1:0]  mem_st_reg,
   input logic [DATA_W-1:0] mem_st_data,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b,
   input logic              sel_st,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [DATA_W-1:0] st_wdata
);

   always_comb begin
      assert_no_code3_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);

      assert_xm_cause_a_R1: assert (sel_a != 2'b10 || (xm_wr_en && xm_rd == ex_rs_a));
      assert_xm_cause_b_R2: assert (sel_b != 2'b10 || (xm_wr_en && xm_rd == ex_rs_b));

      assert_wb_cause_a_R3: assert (sel_a != 2'b01 ||
         (mw_wr_en && mw_rd == ex_rs_a && !(xm_wr_en && xm_rd == ex_rs_a)));
      assert_wb_cause_b_R3: assert (sel_b != 2'b01 ||
         (mw_wr_en && mw_rd == ex_rs_b && !(xm_wr_en && xm_rd == ex_rs_b)));

      assert_newest_wins_R5: assert (!(xm_wr_en && mw_wr_en && xm_rd == ex_rs_a &&
         mw_rd == ex_rs_a && ex_rs_a != '0) || sel_a == 2'b10);

      if (SKIP_ZERO) begin
         assert_zero_a_R6: assert (ex_rs_a != '0 || sel_a == 2'b00);
         assert_zero_b_R6: assert (ex_rs_b != '0 || sel_b == 2'b00);
         assert_zero_st_R6: assert (mem_st_reg != '0 || !sel_st);
      end

      assert_rf_path_R4: assert (sel_a != 2'b00 || op_a == ex_rf_a);
      assert_data_a_R9: assert ((sel_a != 2'b01 || op_a == mw_result) &&
                                (sel_a != 2'b10 || op_a == xm_result));
      assert_data_b_R9: assert ((sel_b == 2'b00 && op_b == ex_rf_b) ||
                                (sel_b == 2'b01 && op_b == mw_result) ||
                                (sel_b == 2'b10 && op_b == xm_result));

      assert_store_data_R7: assert (sel_st ? (st_wdata == mw_result && mem_st_reg == mw_rd)
                                           : (st_wdata == mem_st_data));
   end

endmodule

bind fwd_unit fwd_unit_chk #(
   .REG_W    (REG_W),
   .DATA_W   (DATA_W),
   .SKIP_ZERO(SKIP_ZERO)
) u_chk (
   .ex_rs_a    (ex_rs_a),
   .ex_rs_b    (ex_rs_b),
   .ex_rf_a    (ex_rf_a),
   .ex_rf_b    (ex_rf_b),
   .xm_wr_en   (xm_wr_en),
   .xm_rd      (xm_rd),
   .xm_result  (xm_result),
   .mw_wr_en   (mw_wr_en),
   .mw_rd      (mw_rd),
   .mw_result  (mw_result),
   .mem_st_reg (mem_st_reg),
   .mem_st_data(mem_st_data),
   .sel_a      (sel_a),
   .sel_b      (sel_b),
   .sel_st     (sel_st),
   .op_a       (op_a),
   .op_b       (op_b),
   .st_wdata   (st_wdata)
);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

   localparam int unsigned RW = 5;
   localparam int unsigned DW = 32;

   localparam logic [DW-1:0] RF_A = 32'h0A0A_0001;
   localparam logic [DW-1:0] RF_B = 32'h0B0B_0002;
   localparam logic [DW-1:0] XM_V = 32'hC0DE_0003;
   localparam logic [DW-1:0] MW_V = 32'hFFFF_FFFE;
   localparam logic [DW-1:0] ST_V = 32'h5151_0004;

   typedef struct packed {
      logic [RW-1:0] ra;
      logic [RW-1:0] rb;
      logic          xwe;
      logic [RW-1:0] xrd;
      logic          mwe;
      logic [RW-1:0] mrd;
      logic [1:0]    ea;
      logic [1:0]    eb;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{5'd1,  5'd2,  1'b0, 5'd1,  1'b0, 5'd2,  2'b00, 2'b00}, // R4 no writers
      '{5'd2,  5'd5,  1'b1, 5'd2,  1'b0, 5'd0,  2'b10, 2'b00}, // R1
      '{5'd6,  5'd2,  1'b1, 5'd2,  1'b0, 5'd0,  2'b00, 2'b10}, // R2
      '{5'd6,  5'd2,  1'b0, 5'd0,  1'b1, 5'd2,  2'b00, 2'b01}, // R3 operand b
      '{5'd2,  5'd7,  1'b1, 5'd9,  1'b1, 5'd2,  2'b01, 2'b00}, // R3 operand a
      '{5'd1,  5'd4,  1'b1, 5'd1,  1'b1, 5'd1,  2'b10, 2'b00}, // R5
      '{5'd2,  5'd2,  1'b1, 5'd2,  1'b1, 5'd2,  2'b10, 2'b10}, // R5 both ops
      '{5'd3,  5'd4,  1'b1, 5'd3,  1'b1, 5'd4,  2'b10, 2'b01}, // R1 + R3 mix
      '{5'd3,  5'd4,  1'b0, 5'd3,  1'b1, 5'd3,  2'b01, 2'b00}, // R3 xm not writing
      '{5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R6
      '{5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd30, 2'b10, 2'b01}, // R1 top register
      '{5'd8,  5'd8,  1'b0, 5'd8,  1'b0, 5'd8,  2'b00, 2'b00}  // R4 enables low
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [RW-1:0] ex_rs_a, ex_rs_b, xm_rd, mw_rd, mem_st_reg;
   logic [DW-1:0] ex_rf_a, ex_rf_b, xm_result, mw_result, mem_st_data;
   logic          xm_wr_en, mw_wr_en, mw_is_load, mem_is_store;
   logic [1:0]    sel_a, sel_b;
   logic          sel_st;
   logic [DW-1:0] op_a, op_b, st_wdata;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   fwd_unit u_fwd_unit (
      .ex_rs_a     (ex_rs_a),
      .ex_rs_b     (ex_rs_b),
      .ex_rf_a     (ex_rf_a),
      .ex_rf_b     (ex_rf_b),
      .xm_wr_en    (xm_wr_en),
      .xm_rd       (xm_rd),
      .xm_result   (xm_result),
      .mw_wr_en    (mw_wr_en),
      .mw_is_load  (mw_is_load),
      .mw_rd       (mw_rd),
      .mw_result   (mw_result),
      .mem_is_store(mem_is_store),
      .mem_st_reg  (mem_st_reg),
      .mem_st_data (mem_st_data),
      .sel_a       (sel_a),
      .sel_b       (sel_b),
      .sel_st      (sel_st),
      .op_a        (op_a),
      .op_b        (op_b),
      .st_wdata    (st_wdata)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
      return (s == 2'b10) ? XM_V : (s == 2'b01) ? MW_V : rf;
   endfunction

   task automatic idle_inputs();
      ex_rs_a = '0; ex_rs_b = '0; ex_rf_a = RF_A; ex_rf_b = RF_B;
      xm_wr_en = 1'b0; xm_rd = '0; xm_result = XM_V;
      mw_wr_en = 1'b0; mw_is_load = 1'b0; mw_rd = '0; mw_result = MW_V;
      mem_is_store = 1'b0; mem_st_reg = '0; mem_st_data = ST_V;
   endtask

   task automatic store_case(input string req, input logic st, input logic ld,
                             input logic we, input logic [RW-1:0] sreg,
                             input logic [RW-1:0] wrd, input logic exp_sel);
      @(negedge clk);
      idle_inputs();
      mem_is_store = st; mw_is_load = ld; mw_wr_en = we;
      mem_st_reg = sreg; mw_rd = wrd;
      #1;
      check(req, "sel_st", {31'd0, sel_st}, {31'd0, exp_sel});
      check(req, "st_wdata", st_wdata, exp_sel ? MW_V : ST_V);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      #1;
      // Reset state: idle pipeline forwards nothing (R4)
      check("R4", "reset sel_a", {30'd0, sel_a}, 32'd0);
      check("R4", "reset sel_b", {30'd0, sel_b}, 32'd0);
      check("R7", "reset sel_st", {31'd0, sel_st}, 32'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         idle_inputs();
         ex_rs_a = VECS[i].ra; ex_rs_b = VECS[i].rb;
         xm_wr_en = VECS[i].xwe; xm_rd = VECS[i].xrd;
         mw_wr_en = VECS[i].mwe; mw_rd = VECS[i].mrd;
         #1;
         check("R1/R3/R5 vec", "sel_a", {30'd0, sel_a}, {30'd0, VECS[i].ea});
         check("R2/R3/R5 vec", "sel_b", {30'd0, sel_b}, {30'd0, VECS[i].eb});
         check("R9", "op_a", op_a, pick(VECS[i].ea, RF_A));
         check("R9", "op_b", op_b, pick(VECS[i].eb, RF_B));
         check("R8", "no code 3", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
      end

      // R6: register zero with a matching writer in both stages
      @(negedge clk);
      idle_inputs();
      ex_rs_a = '0; ex_rs_b = 5'd9; xm_wr_en = 1'b1; xm_rd = '0;
      mw_wr_en = 1'b1; mw_rd = '0;
      #1;
      check("R6", "sel_a zero", {30'd0, sel_a}, 32'd0);
      check("R6", "op_a zero", op_a, RF_A);

      // R7: store bypass directed cases
      store_case("R7", 1'b1, 1'b1, 1'b1, 5'd1,  5'd1,  1'b1);
      store_case("R7", 1'b1, 1'b1, 1'b1, 5'd31, 5'd31, 1'b1);
      store_case("R7", 1'b0, 1'b1, 1'b1, 5'd1,  5'd1,  1'b0);
      store_case("R7", 1'b1, 1'b0, 1'b1, 5'd1,  5'd1,  1'b0);
      store_case("R7", 1'b1, 1'b1, 1'b0, 5'd1,  5'd1,  1'b0);
      store_case("R7", 1'b1, 1'b1, 1'b1, 5'd1,  5'd2,  1'b0);
      store_case("R6", 1'b1, 1'b1, 1'b1, 5'd0,  5'd0,  1'b0);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule